// File: doc/BRIEF.md
# Saturating 16-bit ALU with Status Flags

This block is the arithmetic and logic stage of a signal-processing datapath. Every clock it combines an X operand with a Y operand and forms a 16-bit result. The Y operand comes either from an external port or from an internal feedback register. The carry input of the add-with-carry and subtract-with-borrow operations is the carry flag left by the previous operation.

Five status flags are captured at the end of every cycle: zero, negative, carry, overflow and the sign of X. The result may be written to a result register, to the feedback register, to both, or to neither. When the saturation mode input is high, the value written to the result register is clamped on overflow. The overflow and carry of that same operation choose the clamp value. The feedback register always receives the unclamped result, so a chain of operations can continue from it on the next cycle.

Top module: `sat_alu`

## Requirements
- R1: While reset is low, `result_o`, `feedback_o` and `flags_o` are all zero.
- R2: Opcodes are 0 X+Y, 1 X+Y+CI, 2 X−Y, 3 X−Y+CI−1, 4 Y−X, 5 Y−X+CI−1, 6 −X, 7 X+1, 8 X−1, 9 pass Y, 10 clear, 11 |X|, 12 X AND Y, 13 X OR Y, 14 X XOR Y, 15 NOT X. All results are taken modulo 2^16.
- R3: CI in opcodes 1, 3 and 5 is the registered carry flag `flags_o[2]` from the previous cycle.
- R4: Carry `flags_o[2]` is set for an addition with an unsigned carry out of bit 15, and for a subtraction with no unsigned borrow. Overflow `flags_o[3]` is set when the signed two's-complement result lies outside −32768..32767. An addition of operands of opposite sign never sets it.
- R5: Opcodes 9, 10 and 12 to 15 clear carry and overflow.
- R6: Zero `flags_o[0]` and negative `flags_o[1]` come from the 16-bit unclamped result. X-sign `flags_o[4]` is bit 15 of X. All flags update on every clock edge after reset.
- R7: With `sat_en_i` low, a write to the result register stores the unclamped result.
- R8: With `sat_en_i` high and overflow clear, the result register stores the unclamped result, whatever the carry.
- R9: With `sat_en_i` high, overflow set and carry clear, the result register stores 0x7FFF.
- R10: With `sat_en_i` high and both overflow and carry set, the result register stores 0x8000.
- R11: `dest_i` selects the write: 0 writes nothing and both registers hold, 1 writes the result register, 2 writes the feedback register with the unclamped value, 3 writes both.
- R12: With `y_sel_fb_i` high, Y is the feedback register, so a value written in one cycle is the operand of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| x_i | input | 16 | X operand |
| y_i | input | 16 | External Y operand |
| y_sel_fb_i | input | 1 | Selects the feedback register as Y |
| dest_i | input | 2 | Write destination |
| sat_en_i | input | 1 | Saturation mode |
| result_o | output | 16 | Result register |
| feedback_o | output | 16 | Feedback register |
| flags_o | output | 5 | {X-sign, overflow, carry, negative, zero} |

## Verification
The bench builds the block at its default width of 16. At this width the clamp values 0x7FFF and 0x8000, the most negative operand and the carry out of bit 15 can all be reached with literal operands. A behavioural reference model works on signed and unsigned integers and predicts all three registers for every cycle. It covers directed corners: negating and taking the absolute value of 0x8000, incrementing 0xFFFF and decrementing 0. It also runs a random stream that mixes destinations, feedback selection and saturation.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_SUB  = 4'd2,  OP_SBB  = 4'd3,
    OP_RSB  = 4'd4,  OP_RSBB = 4'd5,  OP_NEG  = 4'd6,  OP_INC  = 4'd7,
    OP_DEC  = 4'd8,  OP_PASS = 4'd9,  OP_CLR  = 4'd10, OP_ABS  = 4'd11,
    OP_AND  = 4'd12, OP_OR   = 4'd13, OP_XOR  = 4'd14, OP_NOT  = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic xs;
    logic v;
    logic c;
    logic n;
    logic z;
  } alu_flags_t;

  localparam int FLAG_W = $bits(alu_flags_t);
endpackage

// File: rtl/sat_alu_core.sv
module sat_alu_core
  import sat_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         v_out
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONES = '1;

  function automatic logic [W:0] add3(input logic [W-1:0] a, input logic [W-1:0] b,
                                      input logic cin);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  endfunction

  function automatic logic ovf(input logic [W-1:0] a, input logic [W-1:0] b,
                               input logic [W-1:0] s);
    return (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
  endfunction

  logic [W-1:0] a, b;
  logic         cin, is_logic;
  logic [W:0]   sum;
  logic [W-1:0] lres;

  always_comb begin
    a = x; b = ZERO; cin = 1'b0; is_logic = 1'b0; lres = ZERO;
    unique case (op)
      OP_ADD:  begin b = y; end
      OP_ADC:  begin b = y; cin = ci; end
      OP_SUB:  begin b = ~y; cin = 1'b1; end
      OP_SBB:  begin b = ~y; cin = ci; end
      OP_RSB:  begin a = y; b = ~x; cin = 1'b1; end
      OP_RSBB: begin a = y; b = ~x; cin = ci; end
      OP_NEG:  begin a = ZERO; b = ~x; cin = 1'b1; end
      OP_INC:  begin cin = 1'b1; end
      OP_DEC:  begin b = ONES; end
      OP_PASS: begin a = y; end
      OP_CLR:  begin a = ZERO; end
      OP_ABS:  begin
        if (x[W-1]) begin a = ZERO; b = ~x; cin = 1'b1; end
      end
      OP_AND:  begin is_logic = 1'b1; lres = x & y; end
      OP_OR:   begin is_logic = 1'b1; lres = x | y; end
      OP_XOR:  begin is_logic = 1'b1; lres = x ^ y; end
      OP_NOT:  begin is_logic = 1'b1; lres = ~x; end
      default: ;
    endcase
  end

  assign sum   = add3(a, b, cin);
  assign res   = is_logic ? lres : sum[W-1:0];
  assign c_out = is_logic ? 1'b0 : sum[W];
  assign v_out = is_logic ? 1'b0 : ovf(a, b, sum[W-1:0]);
endmodule

// File: rtl/sat_alu_clamp.sv
module sat_alu_clamp #(
  parameter int W = 16
) (
  input  logic [W-1:0] raw,
  input  logic         v,
  input  logic         c,
  input  logic         en,
  output logic [W-1:0] clamped,
  output logic         clamp_hi,
  output logic         clamp_lo
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  assign clamp_hi = en & v & ~c;
  assign clamp_lo = en & v & c;
  assign clamped  = clamp_hi ? MAX_POS : (clamp_lo ? MAX_NEG : raw);
endmodule

// File: rtl/sat_alu_status.sv
module sat_alu_status
  import sat_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  input  logic         c,
  input  logic         v,
  input  logic         x_msb,
  output alu_flags_t   flags
);
  alu_flags_t nxt;

  always_comb begin
    nxt.z  = (raw == '0);
    nxt.n  = raw[W-1];
    nxt.c  = c;
    nxt.v  = v;
    nxt.xs = x_msb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [W-1:0]      x_i,
  input  logic [W-1:0]      y_i,
  input  logic              y_sel_fb_i,
  input  logic [1:0]        dest_i,
  input  logic              sat_en_i,
  output logic [W-1:0]      result_o,
  output logic [W-1:0]      feedback_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [W-1:0] res_q, fb_q, y_eff, raw, clamped;
  logic         c_now, v_now, clamp_hi, clamp_lo, wr_res, wr_fb;
  alu_flags_t   flags_q;

  assign y_eff  = y_sel_fb_i ? fb_q : y_i;
  assign wr_res = dest_i[0];
  assign wr_fb  = dest_i[1];

  sat_alu_core #(.W(W)) u_core (
    .op(alu_op_e'(op_i)), .x(x_i), .y(y_eff), .ci(flags_q.c),
    .res(raw), .c_out(c_now), .v_out(v_now)
  );

  sat_alu_clamp #(.W(W)) u_clamp (
    .raw(raw), .v(v_now), .c(c_now), .en(sat_en_i),
    .clamped(clamped), .clamp_hi(clamp_hi), .clamp_lo(clamp_lo)
  );

  sat_alu_status #(.W(W)) u_status (
    .clk(clk), .rst_n(rst_n), .raw(raw), .c(c_now), .v(v_now),
    .x_msb(x_i[W-1]), .flags(flags_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      fb_q  <= '0;
    end else begin
      if (wr_res) res_q <= clamped;
      if (wr_fb)  fb_q  <= raw;
    end
  end

  assign result_o   = res_q;
  assign feedback_o = fb_q;
  assign flags_o    = flags_q;
endmodule

// File: rtl/sat_alu_checker.sv
module sat_alu_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op_i,
  input logic [W-1:0] x_i,
  input logic [W-1:0] y_eff,
  input logic         sat_en_i,
  input logic         wr_res,
  input logic         wr_fb,
  input logic [W-1:0] raw,
  input logic         c_now,
  input logic         v_now,
  input logic         clamp_hi,
  input logic         clamp_lo,
  input logic [W-1:0] result_o,
  input logic [W-1:0] feedback_o,
  input logic [4:0]   flags_o
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  assert_add_opp_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd0 && x_i[W-1] != y_eff[W-1]) |=> !flags_o[3]);

  assert_logic_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 4'd12) |=> (flags_o[2] == 1'b0 && flags_o[3] == 1'b0));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flags_o[0] == ($past(raw) == '0)));

  assert_sat_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_en_i && !v_now && wr_res) |=> (result_o == $past(raw)));

  assert_sat_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_en_i && v_now && !c_now && wr_res) |=> (result_o == MAX_POS));

  assert_sat_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_en_i && v_now && c_now && wr_res) |=> (result_o == MAX_NEG));

  assert_clamp_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clamp_hi, clamp_lo}));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_res && !wr_fb) |=> ($stable(result_o) && $stable(feedback_o)));

  assert_fb_raw_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fb |=> (feedback_o == $past(raw)));
endmodule

bind sat_alu sat_alu_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .x_i(x_i), .y_eff(y_eff),
  .sat_en_i(sat_en_i), .wr_res(wr_res), .wr_fb(wr_fb), .raw(raw),
  .c_now(c_now), .v_now(v_now), .clamp_hi(clamp_hi), .clamp_lo(clamp_lo),
  .result_o(result_o), .feedback_o(feedback_o), .flags_o(flags_o)
);

// File: tb/sat_alu_test.sv
module sat_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = 4'd10;
  logic [15:0] x_i = '0, y_i = '0;
  logic        y_sel_fb_i = 1'b0, sat_en_i = 1'b0;
  logic [1:0]  dest_i = 2'd0;
  logic [15:0] result_o, feedback_o;
  logic [4:0]  flags_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] m_res = '0, m_fb = '0;
  logic [4:0]  m_fl = '0;

  always #4 clk = ~clk;

  sat_alu uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .x_i(x_i), .y_i(y_i),
    .y_sel_fb_i(y_sel_fb_i), .dest_i(dest_i), .sat_en_i(sat_en_i),
    .result_o(result_o), .feedback_o(feedback_o), .flags_o(flags_o)
  );

  task automatic compare(input string tag);
    n_cmp++;
    if (result_o !== m_res || feedback_o !== m_fb || flags_o !== m_fl) begin
      n_bad++;
      $display("FAIL %s: res=%h fb=%h fl=%b expected res=%h fb=%h fl=%b",
               tag, result_o, feedback_o, flags_o, m_res, m_fb, m_fl);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [15:0] x, input logic [15:0] y,
                      input logic sel, input logic [1:0] dst, input logic sat,
                      input string tag);
    int ux, uy, sx, sy, ci, u, s;
    logic [15:0] yv, r;
    logic c, v;
    op_i = op; x_i = x; y_i = y; y_sel_fb_i = sel; dest_i = dst; sat_en_i = sat;
    yv = sel ? m_fb : y;
    ux = int'(x); uy = int'(yv); sx = int'($signed(x)); sy = int'($signed(yv));
    ci = int'(m_fl[2]); c = 1'b0; u = 0; s = 0;
    case (op)
      4'd0:  begin u = ux + uy;          s = sx + sy;          c = (u > 65535); end
      4'd1:  begin u = ux + uy + ci;     s = sx + sy + ci;     c = (u > 65535); end
      4'd2:  begin u = ux - uy;          s = sx - sy;          c = (u >= 0); end
      4'd3:  begin u = ux - uy + ci - 1; s = sx - sy + ci - 1; c = (u >= 0); end
      4'd4:  begin u = uy - ux;          s = sy - sx;          c = (u >= 0); end
      4'd5:  begin u = uy - ux + ci - 1; s = sy - sx + ci - 1; c = (u >= 0); end
      4'd6:  begin u = -ux;              s = -sx;              c = (u >= 0); end
      4'd7:  begin u = ux + 1;           s = sx + 1;           c = (u > 65535); end
      4'd8:  begin u = ux - 1;           s = sx - 1;           c = (u >= 0); end
      4'd9:  begin u = uy; s = sy; end
      4'd10: begin u = 0;  s = 0;  end
      4'd11: begin
        if (sx < 0) begin u = -ux; s = -sx; end
        else        begin u = ux;  s = sx;  end
      end
      4'd12: u = int'(x & yv);
      4'd13: u = int'(x | yv);
      4'd14: u = int'(x ^ yv);
      default: u = int'(~x);
    endcase
    v = (op < 4'd12) && (s > 32767 || s < -32768);
    r = u[15:0];
    @(posedge clk);
    if (dst[0]) m_res = (sat && v) ? (c ? 16'h8000 : 16'h7FFF) : r;
    if (dst[1]) m_fb = r;
    m_fl = {x[15], v, c, r[15], (r == 16'h0)};
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    // R2 basic arithmetic
    step(4'd0, 16'h1234, 16'h0001, 0, 2'd1, 0, "R2 add");
    step(4'd0, 16'hFFFF, 16'h0001, 0, 2'd1, 0, "R4 carry out, zero");
    step(4'd1, 16'h0001, 16'h0001, 0, 2'd1, 0, "R3 adc ci=1");
    step(4'd2, 16'h0005, 16'h0007, 0, 2'd1, 0, "R4 sub borrow");
    step(4'd3, 16'h000A, 16'h0003, 0, 2'd1, 0, "R3 sbb ci=0");
    step(4'd2, 16'h0007, 16'h0005, 0, 2'd1, 0, "R4 sub no borrow");
    step(4'd3, 16'h000A, 16'h0003, 0, 2'd1, 0, "R3 sbb ci=1");
    step(4'd4, 16'h0008, 16'h0003, 0, 2'd1, 0, "R2 rsb");
    step(4'd5, 16'h0002, 16'h0009, 0, 2'd1, 0, "R3 rsbb");
    step(4'd6, 16'h0000, 16'h0000, 0, 2'd1, 0, "R2 neg zero");
    step(4'd6, 16'h8000, 16'h0000, 0, 2'd1, 0, "R4 neg min");
    step(4'd7, 16'hFFFF, 16'h0000, 0, 2'd1, 0, "R2 inc wrap");
    step(4'd8, 16'h0000, 16'h0000, 0, 2'd1, 0, "R2 dec wrap");
    step(4'd0, 16'h7FFF, 16'h7FFF, 0, 2'd1, 0, "R4 set flags");
    step(4'd9, 16'h8000, 16'hBEEF, 0, 2'd1, 0, "R5 pass clears");
    step(4'd10, 16'h1111, 16'h2222, 0, 2'd1, 0, "R5 clear");
    step(4'd11, 16'hFFF0, 16'h0000, 0, 2'd1, 0, "R2 abs neg");
    step(4'd11, 16'h8000, 16'h0000, 0, 2'd1, 1, "R9 abs min sat");
    step(4'd0, 16'h8000, 16'h8000, 0, 2'd1, 0, "R4 set c v");
    step(4'd12, 16'hF0F0, 16'h3C3C, 0, 2'd1, 0, "R5 and");
    step(4'd13, 16'hF0F0, 16'h3C3C, 0, 2'd1, 0, "R5 or");
    step(4'd14, 16'hF0F0, 16'h3C3C, 0, 2'd1, 0, "R5 xor");
    step(4'd15, 16'hF0F0, 16'h0000, 0, 2'd1, 0, "R5 not");
    step(4'd0, 16'h7FFF, 16'h0001, 0, 2'd1, 0, "R4 pos overflow");
    step(4'd0, 16'h7FFF, 16'h8000, 0, 2'd1, 0, "R4 opposite signs");
    step(4'd0, 16'h0008, 16'h0010, 0, 2'd1, 0, "R6 xsign low");
    step(4'd0, 16'h7FFF, 16'h0001, 0, 2'd1, 0, "R7 sat off wraps");
    step(4'd0, 16'hFFFF, 16'h0001, 0, 2'd1, 1, "R8 sat carry only");
    step(4'd0, 16'h0001, 16'h0002, 0, 2'd1, 1, "R8 sat no ovf");
    step(4'd0, 16'h7FFF, 16'h0001, 0, 2'd1, 1, "R9 sat high");
    step(4'd0, 16'h8000, 16'h8000, 0, 2'd1, 1, "R10 sat low add");
    step(4'd2, 16'h8000, 16'h0001, 0, 2'd1, 1, "R10 sat low sub");
    step(4'd0, 16'h4000, 16'h4000, 0, 2'd0, 1, "R11 dest none");
    step(4'd0, 16'h7FFF, 16'h0001, 0, 2'd2, 1, "R11 fb unclamped");
    step(4'd0, 16'h0100, 16'h0023, 0, 2'd3, 0, "R11 both");
    step(4'd0, 16'h0001, 16'h0000, 1, 2'd2, 0, "R12 fb as Y");
    step(4'd0, 16'h0001, 16'h0000, 1, 2'd2, 0, "R12 accumulate");
    step(4'd9, 16'h0000, 16'h0000, 1, 2'd1, 0, "R12 pass fb");
    for (int i = 0; i < 400; i++) begin
      step(4'($urandom_range(0, 15)), 16'($urandom), 16'($urandom),
           1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), "R2 random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule